// File: doc/BRIEF.md
# Pipelined 4x4 Matrix Transpose

This block turns a 4x4 matrix of 32-bit elements, delivered as four row vectors, into its transpose, delivered as four row vectors whose row i holds what was column i of the input. Each row is a 128-bit word of four lanes, and lane 0 sits in the least significant 32 bits.

The work is split over two registered steps of pairwise unpack operations. The first step interleaves single lanes of adjacent row pairs, which transposes each 2x2 corner block where it stands. The second step interleaves 64-bit halves, which moves the off-diagonal blocks into place. Each step has four unpack units.

A matrix is taken whenever input valid and input ready are both high at a clock edge. Results leave with an output valid flag. The downstream side can stall the whole pipe through its ready input. With no stall, one matrix is taken on every cycle.

Top module: `mtx_transpose4`

## Requirements
- R1: While reset is held and on the first edge after it, `out_valid` is low.
- R2: Output row i, lane j (bits [j*32 +: 32]) equals input row j, lane i of the same matrix, for all i, j in 0..3.
- R3: A matrix taken at edge t, with `out_ready` high at edge t+1, is on the outputs with `out_valid` high right after edge t+1, which is two edges of latency.
- R4: With `out_ready` held high, a new matrix is taken on every edge, and matrices come out in the order they went in, with none lost or duplicated.
- R5: `in_ready` is high exactly when `out_ready` is high, so a downstream stall refuses new input.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all four output rows keep their values on the next edge.
- R7: An edge where `in_valid` is low but the pipe advances produces a slot with `out_valid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A matrix is offered on the input rows |
| in_ready | output | 1 | The block can take a matrix this cycle |
| in_row0 | input | 128 | Input row 0, lane 0 in the low bits |
| in_row1 | input | 128 | Input row 1 |
| in_row2 | input | 128 | Input row 2 |
| in_row3 | input | 128 | Input row 3 |
| out_valid | output | 1 | The output rows hold a transposed matrix |
| out_ready | input | 1 | Downstream takes the output; low stalls the pipe |
| out_row0 | output | 128 | Output row 0 (input column 0) |
| out_row1 | output | 128 | Output row 1 |
| out_row2 | output | 128 | Output row 2 |
| out_row3 | output | 128 | Output row 3 |

## Verification
On every cycle, the assertions check the element mapping of each taken matrix two edges later, the ready coupling, the hold of valid and data under stall, the reset value and the empty slots left by bubbles. Whether matrices stay in order and none is lost or repeated over long runs with stalls and gaps at random points can only be shown by the bench's scoreboard. The same holds for the sustained rate of one matrix per cycle and for data patterns such as all ones and the identity matrix.

// File: rtl/mtx_pkg.sv
`timescale 1ns/1ps
package mtx_pkg;
   // How the four unpack results of a stage are ordered on its outputs.
   // SPLIT: lo(0,1), lo(2,3), hi(0,1), hi(2,3)
   // ADJ:   lo(0,1), hi(0,1), lo(2,3), hi(2,3)
   typedef enum logic {
      ORD_SPLIT = 1'b0,
      ORD_ADJ   = 1'b1
   } pair_order_e;
endpackage

// File: rtl/mtx_unpack_pair.sv
`timescale 1ns/1ps
// Interleaves two half rows piece by piece: out = {a0, b0, a1, b1, ...}
module mtx_unpack_pair #(
   parameter int ELEM_W = 32,
   parameter int LANES  = 4,
   parameter int GRAN   = 1,
   localparam int HALF_W = (LANES / 2) * ELEM_W,
   localparam int ROW_W  = LANES * ELEM_W
) (
   input  logic [HALF_W-1:0] a_half,
   input  logic [HALF_W-1:0] b_half,
   output logic [ROW_W-1:0]  row_o
);
   localparam int PIECE_W = GRAN * ELEM_W;
   localparam int PIECES  = (LANES / 2) / GRAN;

   if ((LANES / 2) % GRAN != 0) begin : g_bad_gran
      $error("mtx_unpack_pair: GRAN must divide half the lane count");
   end

   for (genvar k = 0; k < PIECES; k++) begin : g_piece
      assign row_o[(2*k)*PIECE_W   +: PIECE_W] = a_half[k*PIECE_W +: PIECE_W];
      assign row_o[(2*k+1)*PIECE_W +: PIECE_W] = b_half[k*PIECE_W +: PIECE_W];
   end
endmodule

// File: rtl/mtx_unpack_stage.sv
`timescale 1ns/1ps
// Four pairwise unpack units over four rows at one granularity.
module mtx_unpack_stage
   import mtx_pkg::*;
#(
   parameter int          ELEM_W = 32,
   parameter int          LANES  = 4,
   parameter int          GRAN   = 1,
   parameter pair_order_e ORDER  = ORD_SPLIT,
   localparam int ROW_W  = LANES * ELEM_W
) (
   input  logic [3:0][ROW_W-1:0] rows_i,
   output logic [3:0][ROW_W-1:0] rows_o
);
   localparam int HALF_W = ROW_W / 2;

   for (genvar g = 0; g < 4; g++) begin : g_unit
      // Which row pair feeds output g, and which half of it.
      localparam int SRC  = (ORDER == ORD_SPLIT) ? (g % 2) : (g / 2);
      localparam int HIGH = (ORDER == ORD_SPLIT) ? (g / 2) : (g % 2);
      localparam int LSB  = HIGH * HALF_W;

      logic [HALF_W-1:0] a_h;
      logic [HALF_W-1:0] b_h;
      assign a_h = rows_i[2*SRC][LSB +: HALF_W];
      assign b_h = rows_i[2*SRC+1][LSB +: HALF_W];

      mtx_unpack_pair #(
         .ELEM_W (ELEM_W),
         .LANES  (LANES),
         .GRAN   (GRAN)
      ) u_pair (
         .a_half (a_h),
         .b_half (b_h),
         .row_o  (rows_o[g])
      );
   end
endmodule

// File: rtl/mtx_stage_reg.sv
`timescale 1ns/1ps
// Pipeline register with a valid flag; loads only when en is high.
module mtx_stage_reg #(
   parameter int W = 512
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         valid_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else if (en) begin
         valid_o <= valid_i;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         data_o <= data_i;
      end
   end
endmodule

// File: rtl/mtx_transpose4.sv
`timescale 1ns/1ps
module mtx_transpose4
   import mtx_pkg::*;
#(
   parameter int ELEM_W = 32,
   parameter int LANES  = 4,
   localparam int ROW_W = LANES * ELEM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [ROW_W-1:0] in_row0,
   input  logic [ROW_W-1:0] in_row1,
   input  logic [ROW_W-1:0] in_row2,
   input  logic [ROW_W-1:0] in_row3,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ROW_W-1:0] out_row0,
   output logic [ROW_W-1:0] out_row1,
   output logic [ROW_W-1:0] out_row2,
   output logic [ROW_W-1:0] out_row3
);
   localparam int MAT_W = 4 * ROW_W;

   if (LANES != 4) begin : g_bad_lanes
      $error("mtx_transpose4: LANES must be 4");
   end
   if (ELEM_W < 1) begin : g_bad_width
      $error("mtx_transpose4: ELEM_W must be positive");
   end

   // One enable for both registers: a stall freezes the whole pipe.
   logic advance;
   assign advance  = out_ready;
   assign in_ready = advance;

   logic [3:0][ROW_W-1:0] in_rows;
   assign in_rows = {in_row3, in_row2, in_row1, in_row0};

   // Step one: lane interleave, corner 2x2 blocks transposed in place.
   logic [3:0][ROW_W-1:0] s1_comb;
   mtx_unpack_stage #(
      .ELEM_W (ELEM_W),
      .LANES  (LANES),
      .GRAN   (1),
      .ORDER  (ORD_SPLIT)
   ) u_step1 (
      .rows_i (in_rows),
      .rows_o (s1_comb)
   );

   logic                  s1_valid;
   logic [3:0][ROW_W-1:0] s1_rows;
   mtx_stage_reg #(.W(MAT_W)) u_reg1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (advance),
      .valid_i (in_valid),
      .data_i  (s1_comb),
      .valid_o (s1_valid),
      .data_o  (s1_rows)
   );

   // Step two: half-row interleave, off-diagonal blocks swapped.
   logic [3:0][ROW_W-1:0] s2_comb;
   mtx_unpack_stage #(
      .ELEM_W (ELEM_W),
      .LANES  (LANES),
      .GRAN   (2),
      .ORDER  (ORD_ADJ)
   ) u_step2 (
      .rows_i (s1_rows),
      .rows_o (s2_comb)
   );

   logic [3:0][ROW_W-1:0] s2_rows;
   mtx_stage_reg #(.W(MAT_W)) u_reg2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (advance),
      .valid_i (s1_valid),
      .data_i  (s2_comb),
      .valid_o (out_valid),
      .data_o  (s2_rows)
   );

   assign out_row0 = s2_rows[0];
   assign out_row1 = s2_rows[1];
   assign out_row2 = s2_rows[2];
   assign out_row3 = s2_rows[3];
endmodule

// File: rtl/mtx_transpose4_chk.sv
`timescale 1ns/1ps
module mtx_transpose4_chk #(
   parameter int ELEM_W = 32,
   parameter int LANES  = 4,
   localparam int ROW_W = LANES * ELEM_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [ROW_W-1:0] in_row0,
   input logic [ROW_W-1:0] in_row1,
   input logic [ROW_W-1:0] in_row2,
   input logic [ROW_W-1:0] in_row3,
   input logic             out_valid,
   input logic             out_ready,
   input logic [ROW_W-1:0] out_row0,
   input logic [ROW_W-1:0] out_row1,
   input logic [ROW_W-1:0] out_row2,
   input logic [ROW_W-1:0] out_row3
);
   logic [3:0][ROW_W-1:0] in_m;
   logic [3:0][ROW_W-1:0] out_m;
   assign in_m  = {in_row3, in_row2, in_row1, in_row0};
   assign out_m = {out_row3, out_row2, out_row1, out_row0};

   // R1: first edge after reset leaves the output empty
   a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !out_valid);

   // R3: taken matrix plus one advancing edge gives valid output
   a_r3_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 out_ready |=> out_valid);

   // R5: ready toward the source follows the downstream ready
   a_r5_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == out_ready);

   // R6: stalled output holds valid and data
   a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_m)));

   // R7: a bubble that moves through leaves an empty slot
   a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && in_ready) ##1 out_ready |=> !out_valid);

   // R2: element (i,j) of the output is element (j,i) of the input
   for (genvar i = 0; i < 4; i++) begin : g_row
      for (genvar j = 0; j < 4; j++) begin : g_lane
         a_r2_col_to_row: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) ##1 out_ready |=>
               out_m[i][j*ELEM_W +: ELEM_W] == $past(in_m[j][i*ELEM_W +: ELEM_W], 2));
      end
   end
endmodule

bind mtx_transpose4 mtx_transpose4_chk #(
   .ELEM_W (ELEM_W),
   .LANES  (LANES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_row0   (in_row0),
   .in_row1   (in_row1),
   .in_row2   (in_row2),
   .in_row3   (in_row3),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_row0  (out_row0),
   .out_row1  (out_row1),
   .out_row2  (out_row2),
   .out_row3  (out_row3)
);

// File: tb/mtx_transpose4_test.sv
`timescale 1ns/1ps
module mtx_transpose4_test;
   localparam int EW = 32;
   localparam int LN = 4;
   localparam int RW = LN * EW;
   typedef logic [3:0][RW-1:0] mat_t;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          rst_n;
   logic          in_valid;
   logic          in_ready;
   logic [RW-1:0] in_row0, in_row1, in_row2, in_row3;
   logic          out_valid;
   logic          out_ready;
   logic [RW-1:0] out_row0, out_row1, out_row2, out_row3;

   mtx_transpose4 #(.ELEM_W(EW), .LANES(LN)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_row0   (in_row0),
      .in_row1   (in_row1),
      .in_row2   (in_row2),
      .in_row3   (in_row3),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_row0  (out_row0),
      .out_row1  (out_row1),
      .out_row2  (out_row2),
      .out_row3  (out_row3)
   );

   mat_t out_m;
   assign out_m = {out_row3, out_row2, out_row1, out_row0};

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   bit   mon_en = 1'b0;
   bit   rand_on = 1'b0;
   int   sent = 0;
   int   rcvd = 0;
   int   cyc  = 0;
   mat_t expq[$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic mat_t tp(input mat_t m);
      mat_t r;
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++)
            r[i][j*EW +: EW] = m[j][i*EW +: EW];
      return r;
   endfunction

   function automatic mat_t mk(input int kind, input int seed);
      mat_t m;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            case (kind)
               0:       m[r][c*EW +: EW] = 32'(seed * 256 + r * 16 + c);
               1:       m[r][c*EW +: EW] = '1;
               2:       m[r][c*EW +: EW] = (r == c) ? 32'd1 : 32'd0;
               default: m[r][c*EW +: EW] = $urandom;
            endcase
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input mat_t act, input mat_t exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: call at a falling edge; returns at the falling edge after acceptance.
   task automatic drive(input mat_t m);
      {in_row3, in_row2, in_row1, in_row0} = m;
      in_valid = 1'b1;
      do @(posedge clk); while (!in_ready);
      if (mon_en) begin
         expq.push_back(tp(m));
         sent++;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: scoreboard compare, in order (R2, R4)
   always begin
      @(negedge clk);
      #5;
      if (mon_en && out_valid && out_ready) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R4 unexpected output", out_m, '0);
         end else begin
            mat_t e;
            e = expq.pop_front();
            chk(out_m == e, "R2/R4 scoreboard", out_m, e);
         end
         rcvd++;
      end
   end

   // Random downstream stalls
   always begin
      @(negedge clk);
      if (rand_on) out_ready = ($urandom_range(0, 3) != 0);
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R4 actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      mat_t m1, m2;
      int c0;
      rst_n = 1'b0;
      in_valid = 1'b0;
      out_ready = 1'b1;
      {in_row3, in_row2, in_row1, in_row0} = '0;
      repeat (3) @(negedge clk);
      #5;
      chk(out_valid == 1'b0, "R1 valid in reset", mat_t'(out_valid), '0);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      chk(out_valid == 1'b0, "R1 valid after reset", mat_t'(out_valid), '0);
      chk(in_ready == 1'b1, "R5 ready high", mat_t'(in_ready), mat_t'(1));

      // Latency and mapping, one matrix
      @(negedge clk);
      m1 = mk(0, 1);
      drive(m1);
      #5;
      chk(out_valid == 1'b0, "R3 not after one edge", mat_t'(out_valid), '0);
      @(negedge clk);
      #5;
      chk(out_valid == 1'b1, "R3 valid after two edges", mat_t'(out_valid), mat_t'(1));
      chk(out_m == tp(m1), "R2 counting pattern", out_m, tp(m1));
      @(negedge clk);
      #5;
      chk(out_valid == 1'b0, "R7 bubble slot empty", mat_t'(out_valid), '0);

      // Stall hold
      @(negedge clk);
      m2 = mk(3, 0);
      drive(m2);
      @(negedge clk);
      out_ready = 1'b0;
      #5;
      chk(in_ready == 1'b0, "R5 ready low under stall", mat_t'(in_ready), '0);
      chk(out_valid == 1'b1, "R6 valid at stall start", mat_t'(out_valid), mat_t'(1));
      repeat (3) @(negedge clk);
      #5;
      chk(out_valid == 1'b1, "R6 valid held", mat_t'(out_valid), mat_t'(1));
      chk(out_m == tp(m2), "R6 data held", out_m, tp(m2));
      @(negedge clk);
      out_ready = 1'b1;
      @(negedge clk);
      #5;
      chk(out_valid == 1'b0, "R7 drained after stall", mat_t'(out_valid), '0);

      // Throughput with scoreboard (R4)
      mon_en = 1'b1;
      @(negedge clk);
      c0 = cyc;
      for (int n = 0; n < 16; n++) drive(mk(n % 4, n + 10));
      chk((cyc - c0) == 16, "R4 one per cycle", mat_t'(cyc - c0), mat_t'(16));

      // Random stalls and gaps
      rand_on = 1'b1;
      for (int n = 0; n < 40; n++) begin
         repeat ($urandom_range(0, 2)) @(negedge clk);
         drive(mk(n % 4, n + 50));
      end
      rand_on = 1'b0;
      @(negedge clk);
      out_ready = 1'b1;
      repeat (6) @(negedge clk);
      #5;
      chk(expq.size() == 0, "R4 queue drained", mat_t'(expq.size()), '0);
      chk(rcvd == sent, "R4 count matches", mat_t'(rcvd), mat_t'(sent));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule